// File: doc/BRIEF.md
# Channel Transfer Counter and Activation Enable

This block keeps the transfer-count state for one channel of a small controller that moves data when an interrupt fires. The transfer engine pulses a strobe once for each data unit moved. The block then counts down and flags the end of a block and the end of the whole transfer. It also keeps the channel's activation-enable bit, which hardware clears when the channel is finished.

The mode input selects one of three counting schemes. In normal mode the first count register is one 16-bit down-counter. In repeat and block modes that register is split in two. Its upper byte is a fixed reload value, and its lower byte is an 8-bit down-counter that restarts from the reload value at each block boundary. In block mode a second 16-bit register counts the blocks. Software loads both count registers and the enable bit through plain write ports. In every counter a value of zero stands for the largest count.

Top module: `xfer_count_ctrl`

## Requirements
- R1: While reset is asserted, and until the first transfer after it, both count outputs, both pulse outputs and the enable output are 0.
- R2: In normal mode (mode 0), each strobe decrements the 16-bit count A by one. The end pulse fires when A steps from 1 to 0. A count of 0 means 65536: a strobe takes it to 0xFFFF with no end pulse.
- R3: In repeat (mode 1) and block (mode 2) modes, each strobe decrements the low byte of count A. When a strobe finds the low byte at 1, the low byte is reloaded from the high byte instead, and that strobe is a block boundary. The high byte never changes on a strobe. A low byte of 0 means 256.
- R4: In block mode, each block boundary decrements count B. The end pulse fires at the boundary that finds B at 1. A count B of 0 means 65536.
- R5: In repeat mode, count B holds its value and the end pulse never fires.
- R6: The block pulse and the end pulse each last one cycle. They appear in the cycle after the clock edge that accepted the strobe that caused them.
- R7: The enable bit takes the value written by software. A strobe accepted while the disable flag is 1 clears it.
- R8: A strobe that causes an end pulse clears the enable bit.
- R9: The enable bit keeps its value when there is no software write and no clear condition.
- R10: A hardware clear of the enable bit takes priority over a software write in the same cycle.
- R11: A software write to a count register in the same cycle as a strobe loads the written value. The pulses and the enable clear for that strobe are still judged from the count held before the write.
- R12: Mode 3 counts exactly like normal mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 0 normal, 1 repeat, 2 block, 3 normal |
| disable_after_i | input | 1 | Clear enable after each transfer |
| xfer_stb_i | input | 1 | One data unit transferred |
| cra_we_i | input | 1 | Write count A |
| cra_wdata_i | input | 16 | Value for count A |
| crb_we_i | input | 1 | Write count B |
| crb_wdata_i | input | 16 | Value for count B |
| en_we_i | input | 1 | Write enable bit |
| en_wdata_i | input | 1 | Value for enable bit |
| cra_o | output | 16 | Current count A |
| crb_o | output | 16 | Current count B |
| blk_done_o | output | 1 | Block-boundary pulse |
| xfer_end_o | output | 1 | End-of-transfer pulse |
| act_en_o | output | 1 | Activation-enable bit |

## Verification
The bench drives zero-valued counts in every mode. A design that treated zero as empty would raise the end pulse at once, or fail to wrap to 0xFFFF or 0xFF. It runs more than 256 strobes through a block-mode low byte of zero, which catches a reload that fires one strobe early or late. It also strikes collisions: a software enable set against a hardware clear, and a count write against a strobe. A design with the wrong priority would leave the channel enabled or drop the written count. Repeat-mode runs confirm that count B and the enable bit survive many wraps, which exposes logic that lets the block counter run in the wrong mode.

// File: rtl/xc_pkg.sv
package xc_pkg;
  typedef enum logic [1:0] {
    XC_MODE_NORMAL = 2'd0,
    XC_MODE_REPEAT = 2'd1,
    XC_MODE_BLOCK  = 2'd2,
    XC_MODE_ALT    = 2'd3
  } xc_mode_e;

  function automatic logic xc_is_split(xc_mode_e m);
    return (m == XC_MODE_REPEAT) || (m == XC_MODE_BLOCK);
  endfunction
endpackage

// File: rtl/xc_rst_sync.sv
module xc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/xc_cra_unit.sv
// Count register A: full-width down-counter, or reload byte plus byte counter.
module xc_cra_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             split_i,
  input  logic             dec_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             last_o
);
  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [HALF-1:0]  hi, lo;
  logic             lo_one, full_one;

  assign hi       = cnt_q[CNT_W-1:HALF];
  assign lo       = cnt_q[HALF-1:0];
  assign lo_one   = (lo == HALF'(1));
  assign full_one = (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (we_i) begin
      cnt_d = wdata_i;
    end else if (dec_i) begin
      if (split_i) cnt_d = lo_one ? {hi, hi} : {hi, lo - 1'b1};
      else         cnt_d = cnt_q - 1'b1;
    end
  end

  assign cnt_en = we_i | dec_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = split_i & dec_i & lo_one;
  assign last_o = ~split_i & dec_i & full_one;
endmodule

// File: rtl/xc_down_ctr.sv
module xc_down_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (we_i)       cnt_d = wdata_i;
    else if (dec_i) cnt_d = cnt_q - 1'b1;
  end

  assign cnt_en = we_i | dec_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign last_o = dec_i & (cnt_q == W'(1));
endmodule

// File: rtl/xc_enable_ctl.sv
module xc_enable_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_we_i,
  input  logic sw_d_i,
  input  logic hw_clr_i,
  output logic en_o
);
  logic en_q, en_d, upd;

  always_comb begin
    en_d = en_q;
    if (hw_clr_i)     en_d = 1'b0;
    else if (sw_we_i) en_d = sw_d_i;
  end

  assign upd = hw_clr_i | sw_we_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   en_q <= 1'b0;
    else if (upd) en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/xfer_count_ctrl.sv
module xfer_count_ctrl
  import xc_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int RST_SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             disable_after_i,
  input  logic             xfer_stb_i,
  input  logic             cra_we_i,
  input  logic [CNT_W-1:0] cra_wdata_i,
  input  logic             crb_we_i,
  input  logic [CNT_W-1:0] crb_wdata_i,
  input  logic             en_we_i,
  input  logic             en_wdata_i,
  output logic [CNT_W-1:0] cra_o,
  output logic [CNT_W-1:0] crb_o,
  output logic             blk_done_o,
  output logic             xfer_end_o,
  output logic             act_en_o
);
  xc_mode_e mode;
  logic     rst_sync_n;
  logic     split, is_block;
  logic     cra_wrap, cra_last, crb_dec, crb_last;
  logic     end_d, blk_d, hw_clr;
  logic     end_q, blk_q;

  assign mode     = xc_mode_e'(mode_i);
  assign split    = xc_is_split(mode);
  assign is_block = (mode == XC_MODE_BLOCK);

  xc_rst_sync #(.STAGES(RST_SYNC)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_sync_n)
  );

  xc_cra_unit #(.CNT_W(CNT_W)) u_cra (
    .clk(clk), .rst_n(rst_sync_n), .split_i(split), .dec_i(xfer_stb_i),
    .we_i(cra_we_i), .wdata_i(cra_wdata_i), .cnt_o(cra_o),
    .wrap_o(cra_wrap), .last_o(cra_last)
  );

  assign crb_dec = is_block & cra_wrap;

  xc_down_ctr #(.W(CNT_W)) u_crb (
    .clk(clk), .rst_n(rst_sync_n), .we_i(crb_we_i), .wdata_i(crb_wdata_i),
    .dec_i(crb_dec), .cnt_o(crb_o), .last_o(crb_last)
  );

  assign end_d  = cra_last | crb_last;
  assign blk_d  = cra_wrap;
  assign hw_clr = xfer_stb_i & (disable_after_i | end_d);

  xc_enable_ctl u_en (
    .clk(clk), .rst_n(rst_sync_n), .sw_we_i(en_we_i), .sw_d_i(en_wdata_i),
    .hw_clr_i(hw_clr), .en_o(act_en_o)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      end_q <= 1'b0;
      blk_q <= 1'b0;
    end else begin
      end_q <= end_d;
      blk_q <= blk_d;
    end
  end

  assign xfer_end_o = end_q;
  assign blk_done_o = blk_q;
endmodule

// File: rtl/xc_checker.sv
module xc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic             disable_after_i,
  input logic             xfer_stb_i,
  input logic             cra_we_i,
  input logic             crb_we_i,
  input logic             en_we_i,
  input logic [CNT_W-1:0] cra_o,
  input logic [CNT_W-1:0] crb_o,
  input logic             blk_done_o,
  input logic             xfer_end_o,
  input logic             act_en_o
);
  localparam int HALF = CNT_W / 2;

  a_r2_normal_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_stb_i && !cra_we_i && (mode_i == 2'd0 || mode_i == 2'd3))
    |=> cra_o == CNT_W'($past(cra_o) - 1'b1));

  a_r3_reload_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == 2'd1 || mode_i == 2'd2) && !cra_we_i)
    |=> cra_o[CNT_W-1:HALF] == $past(cra_o[CNT_W-1:HALF]));

  a_r5_repeat_crb_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd1 && !crb_we_i) |=> $stable(crb_o));

  a_r6_end_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_stb_i) |=> !xfer_end_o);

  a_r6_blk_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_stb_i) |=> !blk_done_o);

  a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_stb_i && disable_after_i) |=> !act_en_o);

  a_r8_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end_o |-> !act_en_o);

  a_r9_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_stb_i && !en_we_i) |=> $stable(act_en_o));
endmodule

bind xfer_count_ctrl xc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .disable_after_i(disable_after_i),
  .xfer_stb_i(xfer_stb_i), .cra_we_i(cra_we_i), .crb_we_i(crb_we_i),
  .en_we_i(en_we_i), .cra_o(cra_o), .crb_o(crb_o), .blk_done_o(blk_done_o),
  .xfer_end_o(xfer_end_o), .act_en_o(act_en_o)
);

// File: tb/sim_xfer_count_ctrl.sv
`timescale 1ns/1ps
module sim_xfer_count_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_i;
  logic        disable_after_i, xfer_stb_i;
  logic        cra_we_i, crb_we_i, en_we_i, en_wdata_i;
  logic [15:0] cra_wdata_i, crb_wdata_i;
  logic [15:0] cra_o, crb_o;
  logic        blk_done_o, xfer_end_o, act_en_o;

  int checks = 0;
  int fails  = 0;
  int m_cra = 0, m_crb = 0;
  bit m_en = 0, m_blk = 0, m_end = 0;
  string sec = "R1";

  always #2.5 clk = ~clk;

  xfer_count_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .disable_after_i(disable_after_i),
    .xfer_stb_i(xfer_stb_i), .cra_we_i(cra_we_i), .cra_wdata_i(cra_wdata_i),
    .crb_we_i(crb_we_i), .crb_wdata_i(crb_wdata_i), .en_we_i(en_we_i),
    .en_wdata_i(en_wdata_i), .cra_o(cra_o), .crb_o(crb_o),
    .blk_done_o(blk_done_o), .xfer_end_o(xfer_end_o), .act_en_o(act_en_o)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", sec, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(cra_o == m_cra[15:0], "count A", cra_o, m_cra);
    chk(crb_o == m_crb[15:0], "count B", crb_o, m_crb);
    chk(blk_done_o == m_blk, "block pulse", blk_done_o, m_blk);
    chk(xfer_end_o == m_end, "end pulse", xfer_end_o, m_end);
    chk(act_en_o == m_en, "enable", act_en_o, m_en);
  endtask

  // Behavioural reference: one call per clock, inputs held for that cycle.
  task automatic step(input bit stb, input int md, input bit dis,
                      input bit aw, input int ad, input bit bw, input int bd,
                      input bit ew, input bit ed);
    int lo, hi;
    bit clr;
    xfer_stb_i = stb; mode_i = md[1:0]; disable_after_i = dis;
    cra_we_i = aw; cra_wdata_i = ad[15:0];
    crb_we_i = bw; crb_wdata_i = bd[15:0];
    en_we_i = ew; en_wdata_i = ed;
    m_blk = 0; m_end = 0;
    if (stb) begin
      if (md == 1 || md == 2) begin
        hi = m_cra / 256; lo = m_cra % 256;
        if (lo == 1) begin
          lo = hi; m_blk = 1;
          if (md == 2) begin
            if (m_crb == 1) m_end = 1;
            m_crb = (m_crb + 65535) % 65536;
          end
        end else lo = (lo + 255) % 256;
        m_cra = hi * 256 + lo;
      end else begin
        if (m_cra == 1) m_end = 1;
        m_cra = (m_cra + 65535) % 65536;
      end
    end
    clr = stb && (dis || m_end);
    if (aw) m_cra = ad % 65536;
    if (bw) m_crb = bd % 65536;
    if (clr) m_en = 0;
    else if (ew) m_en = ed;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic strobes(input int n, input int md, input bit dis);
    for (int i = 0; i < n; i++) step(1, md, dis, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 0; mode_i = 0; disable_after_i = 0; xfer_stb_i = 0;
    cra_we_i = 0; crb_we_i = 0; en_we_i = 0; en_wdata_i = 0;
    cra_wdata_i = 0; crb_wdata_i = 0;
    repeat (3) @(negedge clk);
    sec = "R1"; compare_all();
    rst_n = 1;
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R2: normal mode countdown to end, then wrap from zero
    sec = "R2";
    step(0, 0, 0, 1, 3, 0, 0, 1, 1);
    strobes(3, 0, 0);
    sec = "R8"; compare_all();
    sec = "R2"; strobes(2, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0, 0, 0);
    strobes(1, 0, 0);

    // R12: mode 3 behaves as normal
    sec = "R12";
    step(0, 3, 0, 1, 2, 0, 0, 1, 1);
    strobes(3, 3, 0);

    // R3 and R5: repeat mode wraps, count B untouched, enable stays
    sec = "R3";
    step(0, 1, 0, 1, 16'h0302, 1, 5, 1, 1);
    strobes(8, 1, 0);
    sec = "R5";
    step(0, 1, 0, 1, 16'h0101, 1, 1, 0, 0);
    strobes(5, 1, 0);
    sec = "R9"; step(0, 1, 0, 0, 0, 0, 0, 0, 0);
    sec = "R7"; strobes(1, 1, 1);
    step(0, 1, 0, 0, 0, 0, 0, 1, 1);

    // R4: block mode ends when count B is exhausted
    sec = "R4";
    step(0, 2, 0, 1, 16'h0202, 1, 2, 1, 1);
    strobes(5, 2, 0);
    // R3 low byte zero means 256; R4 count B zero means 65536
    step(0, 2, 0, 1, 16'h0100, 1, 0, 1, 1);
    strobes(260, 2, 0);

    // R10: hardware clear beats software set
    sec = "R10";
    step(0, 0, 0, 1, 16'h0010, 0, 0, 1, 1);
    step(1, 0, 1, 0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1, 1);
    step(1, 0, 0, 1, 16'h0001, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 1, 1);

    // R11: count write wins over a strobe; pulse judged from old count
    sec = "R11";
    step(0, 0, 0, 1, 16'h0001, 0, 0, 1, 1);
    step(1, 0, 0, 1, 16'h0040, 0, 0, 0, 0);
    step(0, 2, 0, 1, 16'h0501, 1, 1, 1, 1);
    step(1, 2, 0, 0, 0, 1, 16'h0009, 0, 0);

    // R6: mixed traffic checked every cycle against the reference
    sec = "R6";
    for (int i = 0; i < 3000; i++) begin
      bit aw, bw, ew;
      int ad, bd;
      aw = ($urandom % 24) == 0;
      bw = ($urandom % 24) == 0;
      ew = ($urandom % 10) == 0;
      ad = ($urandom % 4) * 256 + ($urandom % 4);
      bd = $urandom % 3;
      step($urandom % 2, $urandom % 4, ($urandom % 12) == 0,
           aw, ad, bw, bd, ew, $urandom % 2);
    end

    finish_run();
  end
endmodule